// File: doc/BRIEF.md
# Configurable Burst Read Address Sequencer

This block steps through the word addresses of a synchronous burst read and drives the WAIT handshake that goes with it. A 16-bit configuration word sets the burst shape. It selects the length (4, 8 or unbounded), the order (linear count or XOR-interleaved), whether a fixed burst wraps inside its aligned block, the initial latency, and the WAIT polarity and timing. The host pulses `addr_latch` with a start address. After the programmed latency, the block presents one word address per cycle while `advance` is high. It raises `data_valid` for each usable word.

A burst that does not wrap can run across a 64-word boundary. When it starts in one of the last few words before that boundary, the array needs extra time to reach the next row. The block then holds the boundary address, drops `data_valid` and asserts WAIT for a number of cycles that depends on how close to the boundary the burst started. The configuration is captured when the address is latched. A new latch aborts whatever burst is in progress.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `data_valid` is low and `burst_wait` is low. Outside a burst, `burst_wait` sits at the deasserted level of the polarity captured by the most recent accepted latch.
- R2: When `cfg[15]` is 1 (asynchronous reads), an `addr_latch` pulse is ignored and no valid data follows.
- R3: `cfg[13:11]` gives the latency L, with codes 0 and 1 both meaning 1. If the latch is sampled at clock edge k, the first valid word appears in the cycle after edge k+L-1, and its address is `start_addr`. Latency cycles show `data_valid` low and WAIT deasserted.
- R4: The length code is `cfg[2:0]`: 001 means 4 words, 010 means 8 words, and any other value means continuous. With `cfg[7]`=1 (sequential) and `cfg[3]`=0 (wrap), a fixed burst counts upward and wraps inside the aligned 4- or 8-word block that holds the start.
- R5: With `cfg[7]`=0 (interleaved) and a fixed length, beat n has address block_base | ((start XOR n) masked to the length), whatever `cfg[3]` holds. Interleaved with continuous length runs linearly.
- R6: A fixed burst gives exactly 4 or 8 valid words and then goes idle, with `data_valid` low.
- R7: With `cfg[3]`=1 (no wrap), or in a continuous burst, beat n has address start + n.
- R8: In a linear burst whose start offset within its 64-word row is 61, 62 or 63, the block inserts 1, 2 or 3 cycles before the first word of the next row. In those cycles `data_valid` is low and WAIT is asserted. Any other start, including an aligned one, gets no such cycles.
- R9: `cfg[10]`=1 makes WAIT active high, and `cfg[10]`=0 makes it active low.
- R10: With `cfg[8]`=1, WAIT is asserted one cycle earlier than the wait cycles it marks. With `cfg[8]`=0, it is asserted during them.
- R11: While `advance` is low, the burst is frozen. The address and `data_valid` hold their values.
- R12: A latch during a burst aborts it, and the new burst starts from its own latency.
- R13: Changes to `cfg` after the latch cycle do not affect the burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 16 | Configuration word |
| addr_latch | input | 1 | Start a burst at `start_addr` |
| start_addr | input | AW | First word address of the burst |
| advance | input | 1 | Burst-continue enable; low freezes the burst |
| word_addr | output | AW | Current word address |
| data_valid | output | 1 | Current word is usable |
| burst_wait | output | 1 | WAIT handshake, polarity and timing set by `cfg` |

## Verification
The bench uses the default parameters: a 21-bit address, 64-word rows and a 4-word wait zone at the end of each row. Because the rows are small, start addresses such as 61, 62, 63 and 128 reach every wait count, the aligned case and a start just outside the zone in a handful of cycles. With 3-bit latency codes, both the shortest and the longest latency fit in short directed bursts. Every length, order and wrap combination is also covered alongside both WAIT polarities and timings.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {LEN_4, LEN_8, LEN_CONT} len_e;

  typedef enum logic [1:0] {PH_IDLE, PH_LAT, PH_DATA} phase_e;

  typedef struct packed {
    logic [2:0] lat;
    logic       wait_high;
    logic       wait_early;
    logic       interleave;
    logic       linear;
    len_e       len;
  } cfg_t;

  // low-order address bits that move inside a fixed burst
  function automatic logic [2:0] len_mask(len_e l);
    case (l)
      LEN_4:   return 3'd3;
      LEN_8:   return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_seq_pkg::*;
(
  input  logic [15:0] raw,
  output logic        async_rd,
  output cfg_t        dec
);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{raw[14], raw[9], raw[6:4]};

  assign async_rd = raw[15];

  always_comb begin
    dec.lat        = (raw[13:11] == 3'd0) ? 3'd1 : raw[13:11];
    dec.wait_high  = raw[10];
    dec.wait_early = raw[8];
    dec.interleave = ~raw[7];
    dec.linear     = raw[3];
    case (raw[2:0])
      3'b001:  dec.len = LEN_4;
      3'b010:  dec.len = LEN_8;
      default: dec.len = LEN_CONT;
    endcase
  end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_seq_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] beat,
  input  cfg_t          mode,
  output logic [AW-1:0] addr
);

  function automatic logic [AW-1:0] map_addr(logic [AW-1:0] s, logic [AW-1:0] n, cfg_t c);
    logic [AW-1:0] m;
    m = {{(AW-3){1'b0}}, len_mask(c.len)};
    if (c.len == LEN_CONT) return s + n;
    if (c.interleave)      return (s & ~m) | ((s ^ n) & m);
    if (c.linear)          return s + n;
    return (s & ~m) | ((s + n) & m);
  endfunction

  assign addr = map_addr(start, beat, mode);

endmodule

// File: rtl/burst_wait_drive.sv
module burst_wait_drive (
  input  logic now_w,
  input  logic next_w,
  input  logic early,
  input  logic act_high,
  output logic pin
);

  logic w;
  assign w   = early ? next_w : now_w;
  assign pin = act_high ? w : ~w;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW       = 21,
  parameter int BOUNDARY = 64,
  parameter int ZONE     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cfg,
  input  logic          addr_latch,
  input  logic [AW-1:0] start_addr,
  input  logic          advance,
  output logic [AW-1:0] word_addr,
  output logic          data_valid,
  output logic          burst_wait
);

  localparam int OFFW       = $clog2(BOUNDARY);
  localparam int WW         = $clog2(ZONE);
  localparam int ZONE_START = BOUNDARY - ZONE;
  localparam cfg_t CFG_RST  = '{lat: 3'd1, wait_high: 1'b1, wait_early: 1'b0,
                                interleave: 1'b0, linear: 1'b0, len: LEN_4};

  function automatic logic [WW-1:0] waits_for(logic [OFFW-1:0] off);
    if (off > OFFW'(ZONE_START)) return WW'(off - OFFW'(ZONE_START));
    return '0;
  endfunction

  logic          cfg_async;
  cfg_t          cfg_live, cfg_q, cfg_n;
  phase_e        phase, phase_n;
  logic [2:0]    lat_cnt, lat_n;
  logic [AW-1:0] beat, beat_n, start_q, start_n;
  logic [WW-1:0] wait_left, wl_n;

  // named internal events
  logic          beat_step, burst_done, boundary_hit, lin_q;
  logic [AW-1:0] cross_beat, last_beat, blk_mask;
  logic [WW-1:0] edge_waits;
  logic          wait_now, wait_next;

  burst_cfg_decode u_dec (.raw(cfg), .async_rd(cfg_async), .dec(cfg_live));

  assign lin_q      = (cfg_q.len == LEN_CONT) || (!cfg_q.interleave && cfg_q.linear);
  assign edge_waits = waits_for(start_q[OFFW-1:0]);
  assign cross_beat = AW'(BOUNDARY) - AW'(start_q[OFFW-1:0]);
  assign blk_mask   = {{(AW-3){1'b0}}, len_mask(cfg_q.len)};
  assign last_beat  = blk_mask;

  always_comb begin
    phase_n = phase; lat_n = lat_cnt; beat_n = beat; wl_n = wait_left;
    start_n = start_q; cfg_n = cfg_q;
    beat_step = 1'b0; burst_done = 1'b0; boundary_hit = 1'b0;
    if (addr_latch && !cfg_async) begin
      phase_n = (cfg_live.lat == 3'd1) ? PH_DATA : PH_LAT;
      lat_n   = cfg_live.lat - 3'd1;
      beat_n  = '0;
      wl_n    = '0;
      start_n = start_addr;
      cfg_n   = cfg_live;
    end else if (advance) begin
      case (phase)
        PH_LAT: begin
          if (lat_cnt <= 3'd1) phase_n = PH_DATA;
          else lat_n = lat_cnt - 3'd1;
        end
        PH_DATA: begin
          if (wait_left != '0) begin
            wl_n = wait_left - 1'b1;
          end else if (cfg_q.len != LEN_CONT && beat == last_beat) begin
            phase_n    = PH_IDLE;
            burst_done = 1'b1;
          end else begin
            beat_n    = beat + 1'b1;
            beat_step = 1'b1;
            if (lin_q && beat_n == cross_beat && edge_waits != '0) begin
              wl_n         = edge_waits;
              boundary_hit = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      lat_cnt   <= '0;
      beat      <= '0;
      wait_left <= '0;
      start_q   <= '0;
      cfg_q     <= CFG_RST;
    end else begin
      phase     <= phase_n;
      lat_cnt   <= lat_n;
      beat      <= beat_n;
      wait_left <= wl_n;
      start_q   <= start_n;
      cfg_q     <= cfg_n;
    end
  end

  assign wait_now   = (phase == PH_DATA) && (wait_left != '0);
  assign wait_next  = (phase_n == PH_DATA) && (wl_n != '0);
  assign data_valid = (phase == PH_DATA) && (wait_left == '0);

  burst_addr_map #(.AW(AW)) u_map (
    .start(start_q), .beat(beat), .mode(cfg_q), .addr(word_addr)
  );

  burst_wait_drive u_wait (
    .now_w(wait_now), .next_w(wait_next), .early(cfg_q.wait_early),
    .act_high(cfg_q.wait_high), .pin(burst_wait)
  );

  // R11: a frozen burst shows the same word
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !advance && !addr_latch) |=> ($stable(word_addr) && $stable(data_valid)));

  // R2: asynchronous mode leaves an idle sequencer idle
  assert_async_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && addr_latch && cfg[15]) |=> !data_valid);

  // R3: the first beat presents the latched start address
  assert_first_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && beat == '0) |-> (word_addr == start_q));

  // R4: wrapping and interleaved fixed bursts never leave their block
  assert_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && cfg_q.len != LEN_CONT && !lin_q) |-> (((word_addr ^ start_q) & ~blk_mask) == '0));

  // R8: an in-cycle WAIT never coincides with valid data
  assert_wait_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_wait == cfg_q.wait_high && !cfg_q.wait_early) |-> !data_valid);

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int AW = 21;
  localparam int LATC = -2, WAITC = -1, IDLEC = -3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cfg = 16'h8000;
  logic          addr_latch = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          advance = 1'b1;
  logic [AW-1:0] word_addr;
  logic          data_valid;
  logic          burst_wait;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .addr_latch(addr_latch),
    .start_addr(start_addr), .advance(advance), .word_addr(word_addr),
    .data_valid(data_valid), .burst_wait(burst_wait)
  );

  function automatic logic [15:0] mk(bit asy, int lat, bit pol, bit early, bit seq,
                                     bit nowrap, logic [2:0] len);
    return {asy, 1'b0, 3'(lat), pol, 1'b0, early, seq, 3'b000, nowrap, len};
  endfunction

  task automatic chk(input string tag, input string what, input bit ok, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic run_burst(input string tag, input logic [15:0] c, input int start,
                           input int n, input int ex [16], input bit fixed, input bit scramble);
    int lat, total;
    bit pol, early;
    int sq [32];
    lat   = (c[13:11] < 3'd2) ? 1 : int'(c[13:11]);
    pol   = c[10];
    early = c[8];
    total = 0;
    for (int i = 1; i < lat; i++) begin sq[total] = LATC; total++; end
    for (int i = 0; i < n; i++) begin sq[total] = ex[i]; total++; end
    sq[total] = fixed ? IDLEC : 0;
    @(negedge clk);
    cfg = c; start_addr = AW'(start); addr_latch = 1'b1;
    @(negedge clk);
    addr_latch = 1'b0;
    if (scramble) cfg = ~c;
    for (int k = 0; k < total; k++) begin
      int code, nxt;
      bit act;
      if (k > 0) @(negedge clk);
      #2;
      code = sq[k];
      nxt  = sq[k+1];
      chk(tag, "data_valid", data_valid == (code >= 0), int'(data_valid), int'(code >= 0));
      if (code >= 0) chk(tag, "word_addr", word_addr == AW'(code), int'(word_addr), code);
      act = early ? (nxt == WAITC) : (code == WAITC);
      chk(tag, "burst_wait", burst_wait == (pol ? act : !act), int'(burst_wait), int'(pol ? act : !act));
    end
    if (fixed) begin
      @(negedge clk); #2;
      chk({tag, " R6"}, "idle data_valid", data_valid == 1'b0, int'(data_valid), 0);
      chk({tag, " R1"}, "idle burst_wait", burst_wait == !pol, int'(burst_wait), int'(!pol));
    end
    cfg = c;
  endtask

  task automatic t_reset();
    #2;
    chk("R1", "reset data_valid", data_valid == 1'b0, int'(data_valid), 0);
    chk("R1", "reset burst_wait", burst_wait == 1'b0, int'(burst_wait), 0);
  endtask

  task automatic t_seq_wrap();
    run_burst("R4", mk(0, 2, 1, 0, 1, 0, 3'b001), 3, 4,
              '{3, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R4", mk(0, 4, 1, 0, 1, 0, 3'b010), 13, 8,
              '{13, 14, 15, 8, 9, 10, 11, 12, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
  endtask

  task automatic t_interleave();
    run_burst("R5", mk(0, 2, 1, 0, 0, 0, 3'b001), 1, 4,
              '{1, 0, 3, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R5", mk(0, 2, 1, 0, 0, 0, 3'b001), 3, 4,
              '{3, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R5", mk(0, 3, 1, 0, 0, 0, 3'b010), 37, 8,
              '{37, 36, 39, 38, 33, 32, 35, 34, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R5", mk(0, 2, 1, 0, 0, 1, 3'b001), 1, 4,
              '{1, 0, 3, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R5", mk(0, 2, 1, 0, 0, 0, 3'b111), 62, 5,
              '{62, 63, WAITC, WAITC, 64, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 0, 0);
  endtask

  task automatic t_linear();
    run_burst("R7", mk(0, 2, 1, 0, 1, 1, 3'b001), 10, 4,
              '{10, 11, 12, 13, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R8", mk(0, 2, 1, 0, 1, 1, 3'b001), 60, 4,
              '{60, 61, 62, 63, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R8", mk(0, 2, 1, 0, 1, 1, 3'b001), 62, 6,
              '{62, 63, WAITC, WAITC, 64, 65, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R8", mk(0, 2, 1, 0, 1, 1, 3'b010), 61, 9,
              '{61, 62, 63, WAITC, 64, 65, 66, 67, 68, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R8", mk(0, 2, 1, 0, 1, 0, 3'b111), 63, 7,
              '{63, WAITC, WAITC, WAITC, 64, 65, 66, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 0, 0);
    run_burst("R8", mk(0, 3, 1, 0, 1, 0, 3'b111), 128, 6,
              '{128, 129, 130, 131, 132, 133, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 0, 0);
  endtask

  task automatic t_polarity();
    run_burst("R9", mk(0, 2, 0, 0, 1, 1, 3'b001), 62, 6,
              '{62, 63, WAITC, WAITC, 64, 65, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
  endtask

  task automatic t_early();
    run_burst("R10", mk(0, 2, 1, 1, 1, 1, 3'b001), 61, 5,
              '{61, 62, 63, WAITC, 64, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R10", mk(0, 2, 0, 1, 1, 1, 3'b001), 62, 6,
              '{62, 63, WAITC, WAITC, 64, 65, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
  endtask

  task automatic t_latency();
    run_burst("R3", mk(0, 0, 1, 0, 1, 0, 3'b001), 0, 4,
              '{0, 1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
    run_burst("R3", mk(0, 7, 1, 0, 1, 0, 3'b001), 6, 4,
              '{6, 7, 4, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
  endtask

  task automatic t_snapshot();
    run_burst("R13", mk(0, 3, 1, 0, 1, 0, 3'b010), 13, 8,
              '{13, 14, 15, 8, 9, 10, 11, 12, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 1);
  endtask

  task automatic t_async();
    @(negedge clk);
    cfg = mk(1, 2, 1, 0, 1, 0, 3'b001); start_addr = AW'(5); addr_latch = 1'b1;
    @(negedge clk);
    addr_latch = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (k > 0) @(negedge clk);
      #2;
      chk("R2", "data_valid", data_valid == 1'b0, int'(data_valid), 0);
      chk("R2", "burst_wait", burst_wait == 1'b0, int'(burst_wait), 0);
    end
  endtask

  task automatic t_hold();
    int expa [7] = '{LATC, 0, 0, 0, 1, 2, 3};
    @(negedge clk);
    cfg = mk(0, 2, 1, 0, 1, 0, 3'b001); start_addr = '0; addr_latch = 1'b1;
    @(negedge clk);
    addr_latch = 1'b0;
    for (int k = 0; k < 7; k++) begin
      if (k > 0) @(negedge clk);
      #2;
      chk("R11", "data_valid", data_valid == (expa[k] >= 0), int'(data_valid), int'(expa[k] >= 0));
      if (expa[k] >= 0) chk("R11", "word_addr", word_addr == AW'(expa[k]), int'(word_addr), expa[k]);
      if (k == 1) advance = 1'b0;
      if (k == 3) advance = 1'b1;
    end
    @(negedge clk); #2;
    chk("R11", "idle data_valid", data_valid == 1'b0, int'(data_valid), 0);
  endtask

  task automatic t_abort();
    run_burst("R12", mk(0, 2, 1, 0, 1, 0, 3'b111), 100, 3,
              '{100, 101, 102, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 0, 0);
    run_burst("R12", mk(0, 3, 1, 0, 1, 0, 3'b001), 201, 4,
              '{201, 202, 203, 200, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 1, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_seq_wrap();
    t_async();
    t_interleave();
    t_linear();
    t_polarity();
    t_early();
    t_latency();
    t_snapshot();
    t_hold();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule